// File: doc/BRIEF.md
# Receive Byte Packetizer with Idle Timeout

This block sits between a receive byte FIFO and an upstream link that carries data in packets. It looks at the FIFO fill level and decides when the buffered bytes leave as one packet. It reads the FIFO head through a show-ahead interface and pops one byte for each accepted output beat. The output is a valid/ready byte stream, and a last flag marks the final byte of each packet.

A packet is released in one of three ways. The first is when the buffer reaches the packet size limit. The second is when the line has been quiet for three character times while bytes are waiting. The third is at once, one byte per packet, when low-latency forwarding is active. Low-latency forwarding is forced on when the configured line rate is slow, because a slow line cannot fill a packet quickly. A separate flag lowers the size limit by one byte for hosts that use the standard serial-class framing. The character-time tick is produced outside the block, from the line rate and the frame length.

Top module: `rxb_packetizer`

## Requirements
- R1: After reset, `m_valid` and `fifo_pop` are low, and they stay low while the FIFO is empty.
- R2: In normal mode, when the FIFO count reaches the size limit, exactly limit bytes leave as one packet, with `m_last` high only on the final byte.
- R3: In normal mode, a FIFO count below the limit is held, with no output, for as long as no character tick arrives.
- R4: When the FIFO is not empty and three `char_tick` pulses have passed since the last byte arrived, every buffered byte leaves as one packet.
- R5: Each arriving byte (a change of `fifo_count` while collecting) restarts the idle count from zero.
- R6: With `cdc_mode` = 1 the size limit is `max_pkt` − 1; with `cdc_mode` = 0 it is `max_pkt`.
- R7: With `low_latency` = 1, every byte leaves as its own one-byte packet (`m_last` = 1 on every beat).
- R8: When `baud_rate` < 40961, low-latency forwarding is forced on even with `low_latency` = 0. At 40961 and above it is not forced.
- R9: While `m_ready` is low, `m_valid`, `m_data` and `m_last` hold. Bytes keep accumulating in the FIFO, and later packets are still capped at the size limit.
- R10: A packet never has zero bytes (`m_valid` only with a non-empty FIFO), and bytes leave in FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_data | input | DATA_W | FIFO head byte (show-ahead) |
| fifo_count | input | CNT_W | Bytes currently in the FIFO |
| fifo_pop | output | 1 | Removes the head byte at the clock edge |
| char_tick | input | 1 | One-cycle pulse per received character time |
| max_pkt | input | CNT_W | Configured maximum packet size |
| cdc_mode | input | 1 | Lowers the size limit by one |
| low_latency | input | 1 | Forward each byte at once |
| baud_rate | input | BAUD_W | Configured line rate in bits per second |
| m_data | output | DATA_W | Packet byte |
| m_valid | output | 1 | Packet byte valid |
| m_last | output | 1 | Final byte of the packet |
| m_ready | input | 1 | Upstream accepts the byte |

## Verification
The bench targets the edges of each release condition:
- **Count one below the limit with no ticks.** A design that released early here would emit a short packet.
- **Bytes spaced two ticks apart.** A timer that did not restart on arrival would flush a partial packet while data is still streaming in.
- **Rate exactly at 40961, then one below.** An off-by-one comparison would switch forwarding mode at the wrong rate.
- **Upstream stalled while ten bytes pile up.** A design without the size cap would emit one oversized packet. One that dropped `m_valid` or advanced the FIFO during the stall would lose or reorder bytes.

The serial-class flag is also checked: a design that ignored it would emit a 64-byte-style full packet one byte too long.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_DRAIN   = 1'b1
    } rxb_state_e;

endpackage

// File: rtl/rxb_limit.sv
// Derives the effective packet size limit and whether single-byte forwarding applies.
module rxb_limit #(
    parameter int CNT_W       = 8,
    parameter int BAUD_W      = 24,
    parameter int LOWLAT_BAUD = 40961
) (
    input  logic [CNT_W-1:0]  max_pkt,
    input  logic              cdc_mode,
    input  logic              low_latency,
    input  logic [BAUD_W-1:0] baud_rate,
    output logic [CNT_W-1:0]  limit,
    output logic              bypass
);

    localparam logic [BAUD_W-1:0] SLOW_RATE = BAUD_W'(LOWLAT_BAUD);

    always_comb begin
        limit = cdc_mode ? (max_pkt - CNT_W'(1)) : max_pkt;
        if (limit == '0) begin
            limit = CNT_W'(1);
        end
        bypass = low_latency | (baud_rate < SLOW_RATE);
    end

endmodule

// File: rtl/rxb_idle_timer.sv
// Counts character ticks while bytes wait and no new byte arrives.
module rxb_idle_timer #(
    parameter int CNT_W      = 8,
    parameter int IDLE_CHARS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             char_tick,
    input  logic             busy,
    output logic             expired
);

    localparam int TW = $clog2(IDLE_CHARS + 1);
    localparam logic [TW-1:0] LIMIT = TW'(IDLE_CHARS);

    typedef struct packed {
        logic [CNT_W-1:0] prev_cnt;
        logic [TW-1:0]    chars;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d          = tmr_q;
        tmr_d.prev_cnt = fifo_count;
        if (busy || fifo_count == '0 || fifo_count != tmr_q.prev_cnt) begin
            tmr_d.chars = '0;
        end else if (char_tick && tmr_q.chars != LIMIT) begin
            tmr_d.chars = tmr_q.chars + TW'(1);
        end
        expired = (tmr_q.chars == LIMIT) && (fifo_count != '0) && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/rxb_packetizer.sv
module rxb_packetizer
    import rxb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int BAUD_W      = 24,
    parameter int IDLE_CHARS  = 3,
    parameter int LOWLAT_BAUD = 40961
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_pop,
    input  logic              char_tick,
    input  logic [CNT_W-1:0]  max_pkt,
    input  logic              cdc_mode,
    input  logic              low_latency,
    input  logic [BAUD_W-1:0] baud_rate,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    input  logic              m_ready
);

    typedef struct packed {
        rxb_state_e       state;
        logic [CNT_W-1:0] remain;
    } pk_t;

    pk_t pk_d, pk_q;

    logic [CNT_W-1:0] limit;
    logic             bypass;
    logic             expired;

    rxb_limit #(
        .CNT_W      (CNT_W),
        .BAUD_W     (BAUD_W),
        .LOWLAT_BAUD(LOWLAT_BAUD)
    ) u_limit (
        .max_pkt    (max_pkt),
        .cdc_mode   (cdc_mode),
        .low_latency(low_latency),
        .baud_rate  (baud_rate),
        .limit      (limit),
        .bypass     (bypass)
    );

    rxb_idle_timer #(
        .CNT_W     (CNT_W),
        .IDLE_CHARS(IDLE_CHARS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_count(fifo_count),
        .char_tick (char_tick),
        .busy      (pk_q.state == ST_DRAIN),
        .expired   (expired)
    );

    always_comb begin
        pk_d     = pk_q;
        fifo_pop = 1'b0;
        m_valid  = 1'b0;
        m_last   = 1'b0;
        m_data   = fifo_data;
        unique case (pk_q.state)
            ST_COLLECT: begin
                if (fifo_count != '0) begin
                    if (bypass) begin
                        pk_d.state  = ST_DRAIN;
                        pk_d.remain = CNT_W'(1);
                    end else if (fifo_count >= limit) begin
                        pk_d.state  = ST_DRAIN;
                        pk_d.remain = limit;
                    end else if (expired) begin
                        pk_d.state  = ST_DRAIN;
                        pk_d.remain = fifo_count;
                    end
                end
            end
            ST_DRAIN: begin
                m_valid = 1'b1;
                m_last  = (pk_q.remain == CNT_W'(1));
                if (m_ready) begin
                    fifo_pop    = 1'b1;
                    pk_d.remain = pk_q.remain - CNT_W'(1);
                    if (pk_q.remain == CNT_W'(1)) begin
                        pk_d.state = ST_COLLECT;
                    end
                end
            end
            default: pk_d = pk_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '{state: ST_COLLECT, remain: '0};
        end else begin
            pk_q <= pk_d;
        end
    end

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int BAUD_W      = 24,
    parameter int LOWLAT_BAUD = 40961
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] m_data,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_last,
    input logic [CNT_W-1:0]  max_pkt,
    input logic              cdc_mode,
    input logic              low_latency,
    input logic [BAUD_W-1:0] baud_rate
);

    logic [CNT_W-1:0] beats_q;
    logic [CNT_W-1:0] cap;

    assign cap = cdc_mode ? (max_pkt - CNT_W'(1)) : max_pkt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (m_valid && m_ready) begin
            beats_q <= m_last ? '0 : beats_q + CNT_W'(1);
        end
    end

    // R2 and R6: no packet grows beyond the effective limit
    p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (beats_q < cap));

    // R7: single-byte packets under low latency
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && low_latency) |-> m_last);

    // R8: slow line rate forces single-byte packets
    p_baudforce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && baud_rate < BAUD_W'(LOWLAT_BAUD)) |-> m_last);

    // R9: a stalled beat holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_last) && $stable(m_data)));

    // R10: never offers a byte from an empty FIFO
    p_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (fifo_count != '0));

endmodule

bind rxb_packetizer rxb_checker #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .BAUD_W     (BAUD_W),
    .LOWLAT_BAUD(LOWLAT_BAUD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_data     (m_data),
    .fifo_count (fifo_count),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_last     (m_last),
    .max_pkt    (max_pkt),
    .cdc_mode   (cdc_mode),
    .low_latency(low_latency),
    .baud_rate  (baud_rate)
);

// File: tb/sim_rxb_packetizer.sv
`timescale 1ns/1ps
module sim_rxb_packetizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fifo_data;
    logic [7:0]  fifo_count;
    logic        fifo_pop;
    logic        char_tick = 1'b0;
    logic [7:0]  max_pkt = 8'd8;
    logic        cdc_mode = 1'b0;
    logic        low_latency = 1'b0;
    logic [23:0] baud_rate = 24'd115200;
    logic [7:0]  m_data;
    logic        m_valid;
    logic        m_last;
    logic        m_ready = 1'b1;

    int checks = 0;
    int failures = 0;

    // FIFO model
    logic [7:0] mem [256];
    int wr_ptr = 0;
    int rd_ptr = 0;
    logic pop_r = 1'b0;
    logic [7:0] push_seq = 8'h10;
    logic [7:0] exp_seq = 8'h10;

    // capture of accepted beats
    logic [7:0] cap_d [256];
    logic       cap_l [256];
    int cap_wr = 0;
    int cap_rd = 0;

    logic tick_en = 1'b0;
    int   tdiv = 0;

    always #2 clk = ~clk;

    assign fifo_count = 8'(wr_ptr - rd_ptr);
    assign fifo_data  = mem[rd_ptr[7:0]];

    rxb_packetizer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_data  (fifo_data),
        .fifo_count (fifo_count),
        .fifo_pop   (fifo_pop),
        .char_tick  (char_tick),
        .max_pkt    (max_pkt),
        .cdc_mode   (cdc_mode),
        .low_latency(low_latency),
        .baud_rate  (baud_rate),
        .m_data     (m_data),
        .m_valid    (m_valid),
        .m_last     (m_last),
        .m_ready    (m_ready)
    );

    always @(posedge clk) begin
        pop_r <= fifo_pop && rst_n;
        if (rst_n && m_valid && m_ready) begin
            cap_d[cap_wr[7:0]] <= m_data;
            cap_l[cap_wr[7:0]] <= m_last;
            cap_wr <= cap_wr + 1;
        end
    end

    always @(negedge clk) begin
        if (pop_r) rd_ptr <= rd_ptr + 1;
        if (!tick_en) begin
            tdiv <= 0;
            char_tick <= 1'b0;
        end else begin
            tdiv <= (tdiv == 9) ? 0 : tdiv + 1;
            char_tick <= (tdiv == 9);
        end
    end

    task automatic push_byte();
        @(negedge clk);
        mem[wr_ptr[7:0]] = push_seq;
        push_seq = push_seq + 8'd1;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) push_byte();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pkt(input int len, input string req);
        int avail;
        bit ok;
        int bad_i;
        avail = cap_wr - cap_rd;
        ok = 1'b1;
        bad_i = -1;
        checks++;
        if (avail < len) begin
            ok = 1'b0;
        end else begin
            for (int i = 0; i < len; i++) begin
                if (ok && (cap_d[(cap_rd + i) % 256] != 8'(exp_seq + 8'(i)) ||
                           cap_l[(cap_rd + i) % 256] != (i == len - 1))) begin
                    ok = 1'b0;
                    bad_i = i;
                end
            end
            cap_rd = cap_rd + len;
            exp_seq = exp_seq + 8'(len);
        end
        if (!ok) begin
            failures++;
            $display("FAIL %s: packet of %0d beats, actual available=%0d first_bad_beat=%0d, expected len=%0d in order with last on final",
                     req, len, avail, bad_i, len);
        end
    endtask

    task automatic expect_quiet(input string req);
        checks++;
        if (cap_wr != cap_rd) begin
            failures++;
            $display("FAIL %s: actual %0d beats released, expected 0", req, cap_wr - cap_rd);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        checks++;
        if (m_valid !== 1'b0 || fifo_pop !== 1'b0) begin
            failures++;
            $display("FAIL R1: in reset valid=%b pop=%b, expected 0 0", m_valid, fifo_pop);
        end
        rst_n = 1'b1;
        idle(10);
        checks++;
        if (m_valid !== 1'b0 || fifo_pop !== 1'b0) begin
            failures++;
            $display("FAIL R1: empty FIFO valid=%b pop=%b, expected 0 0", m_valid, fifo_pop);
        end
        expect_quiet("R1");
    endtask

    task automatic t_size();
        push_n(8);
        idle(30);
        check_pkt(8, "R2");
        expect_quiet("R2");
    endtask

    task automatic t_hold_timeout();
        push_n(5);
        idle(100);
        expect_quiet("R3");
        tick_en = 1'b1;
        idle(60);
        tick_en = 1'b0;
        check_pkt(5, "R4");
    endtask

    task automatic t_restart();
        tick_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            push_byte();
            if (i < 3) idle(14);
        end
        idle(5);
        expect_quiet("R5");
        idle(60);
        tick_en = 1'b0;
        check_pkt(4, "R5");
    endtask

    task automatic t_cdc();
        cdc_mode = 1'b1;
        push_n(10);
        idle(30);
        check_pkt(7, "R6");
        expect_quiet("R6");
        tick_en = 1'b1;
        idle(60);
        tick_en = 1'b0;
        check_pkt(3, "R6");
        cdc_mode = 1'b0;
    endtask

    task automatic t_lowlat();
        low_latency = 1'b1;
        push_n(3);
        idle(20);
        check_pkt(1, "R7");
        check_pkt(1, "R7");
        check_pkt(1, "R7");
        low_latency = 1'b0;
    endtask

    task automatic t_baud();
        baud_rate = 24'd40961;
        push_n(2);
        idle(40);
        expect_quiet("R8");
        baud_rate = 24'd40960;
        idle(20);
        check_pkt(1, "R8");
        check_pkt(1, "R8");
        baud_rate = 24'd115200;
    endtask

    task automatic t_stall();
        max_pkt = 8'd4;
        m_ready = 1'b0;
        push_n(10);
        idle(10);
        checks++;
        if (m_valid !== 1'b1 || m_last !== 1'b0 || fifo_count != 8'd10) begin
            failures++;
            $display("FAIL R9: stalled valid=%b last=%b count=%0d, expected 1 0 10",
                     m_valid, m_last, fifo_count);
        end
        expect_quiet("R9");
        m_ready = 1'b1;
        idle(20);
        check_pkt(4, "R9");
        check_pkt(4, "R9");
        expect_quiet("R9");
        tick_en = 1'b1;
        idle(60);
        tick_en = 1'b0;
        check_pkt(2, "R10");
        max_pkt = 8'd8;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_size();
        t_hold_timeout();
        t_restart();
        t_cdc();
        t_lowlat();
        t_baud();
        t_stall();
        idle(5);
        expect_quiet("R10");
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1-watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule